// File: doc/BRIEF.md
# Capture/compare/PWM timer channel

One timer channel built around a single 16-bit data register. A 4-bit mode field in an 8-bit control register picks its role. In capture role it copies an external free-running timer count into the data register when selected input-pin edges occur. In compare role it watches that count for equality with the data register and then drives the output pin, raises the interrupt flag or pulses a special-event strobe. In PWM role it produces a pulse-width output whose 10-bit duty value is the data register's low byte joined with two control bits.

The timer, the interrupt controller and bus decoding sit outside the channel. The surrounding logic supplies the timer count, a one-cycle strobe for each timer period restart, the raw input pin and simple write ports for the two registers. It reads the registers back, together with the output pin, the flag and the event strobe.

Top module: `ccp_channel`

## Requirements
- R1: Control register layout: bits 3-0 are the mode and bits 5-4 are the two low duty bits. Bits 7-6 always read 0, whatever is written. After reset the control and data registers read 0, and pin_o, flag_o and event_o are 0.
- R2: Modes 0000, 0001 and 0011 are off. In an off mode pin_o is 0, no capture occurs, no match sets the flag and event_o stays 0. Changing the mode clears the output pin state and the capture edge count.
- R3: Mode 0101 captures on each rising edge and mode 0100 on each falling edge of the synchronized pin. A capture copies tmr_i into the data register and sets the flag. Edges of the other polarity are ignored.
- R4: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th. Any mode change restarts the edge count from zero.
- R5: Mode 0010 toggles pin_o on each compare match and sets the flag.
- R6: Mode 1000 drives pin_o low on entry and high on a match. Mode 1001 drives pin_o high on entry and low on a match. Both set the flag on a match.
- R7: Mode 1010 only sets the flag on a match and leaves pin_o unchanged. Mode 1011 sets the flag and drives event_o high for exactly one cycle.
- R8: A match is acted on once per timer value: in the first cycle that tmr_i equals the data register. While the two stay equal, nothing more happens.
- R9: The flag stays set until flag_clr_i is asserted. When a clear and a new event fall in the same cycle, the flag ends up set.
- R10: Any mode 11xx selects PWM with duty = {data[7:0], ctrl[5:4]}. pin_o rises at each period strobe and stays high for exactly duty cycles. A duty of 0 keeps it low.
- R11: A duty written during a PWM period takes effect only at the next period strobe.
- R12: The input pin passes through a two-flop synchronizer and an edge register. A pin change made before clock edge 1 is captured at clock edge 3, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_i | input | 16 | Free-running timer count |
| tmr_wrap_i | input | 1 | One-cycle strobe at each timer period restart |
| pin_i | input | 1 | Raw input pin (asynchronous) |
| ctrl_we_i | input | 1 | Control register write enable |
| ctrl_wdata_i | input | 8 | Control register write data |
| data_we_i | input | 1 | Data register write enable |
| data_wdata_i | input | 16 | Data register write data |
| flag_clr_i | input | 1 | Clears the interrupt flag |
| ctrl_o | output | 8 | Control register readback |
| data_o | output | 16 | Data register readback |
| pin_o | output | 1 | Channel output pin |
| flag_o | output | 1 | Interrupt flag |
| event_o | output | 1 | One-cycle special-event strobe |

## Verification
The bench builds the channel with its default parameters: a 16-bit timer, two low duty bits, a two-stage synchronizer and capture dividers of 4 and 16. With the dividers this small, a full 16-edge capture run and a divider switch made in the middle of a count both fit in a few hundred cycles. A stale edge count then shows up as a capture arriving early. With two low duty bits, a 20-cycle PWM period can measure duty values from 0 to 14 exactly, including a duty change made partway through a period.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  typedef enum logic [1:0] {ROLE_OFF, ROLE_CAP, ROLE_CMP, ROLE_PWM} role_e;
  // order matches mode bits [1:0] of the capture codes
  typedef enum logic [1:0] {CAP_FALL, CAP_RISE, CAP_DIV_A, CAP_DIV_B} cap_sel_e;
  typedef enum logic [1:0] {ACT_TOGGLE, ACT_SET, ACT_CLR, ACT_NONE} cmp_act_e;

  typedef struct packed {
    role_e    role;
    cap_sel_e cap;
    cmp_act_e act;
    logic     entry_lvl;
    logic     evt;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [3:0] m);
    mode_dec_t d;
    d = '0;
    d.act = ACT_NONE;
    casez (m)
      4'b0010: begin d.role = ROLE_CMP; d.act = ACT_TOGGLE; end
      4'b01??: begin d.role = ROLE_CAP; d.cap = cap_sel_e'(m[1:0]); end
      4'b1000: begin d.role = ROLE_CMP; d.act = ACT_SET; end
      4'b1001: begin d.role = ROLE_CMP; d.act = ACT_CLR; d.entry_lvl = 1'b1; end
      4'b1010: begin d.role = ROLE_CMP; end
      4'b1011: begin d.role = ROLE_CMP; d.evt = 1'b1; end
      4'b11??: d.role = ROLE_PWM;
      default: d.role = ROLE_OFF;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/ccp_sync_edge.sv
module ccp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  // STAGES synchronizer flops plus one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/ccp_cap_pre.sv
module ccp_cap_pre
  import ccp_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     clr_i,
  input  cap_sel_e sel_i,
  input  logic     rise_i,
  input  logic     fall_i,
  output logic     fire_o
);
  localparam int DIV_MAX = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int CW      = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

  logic [CW-1:0] cnt_q, lim;
  logic          div_sel;

  always_comb begin
    lim     = (sel_i == CAP_DIV_A) ? CW'(DIV_A - 1) : CW'(DIV_B - 1);
    div_sel = (sel_i == CAP_DIV_A) || (sel_i == CAP_DIV_B);
    unique case (sel_i)
      CAP_FALL: fire_o = en_i & fall_i;
      CAP_RISE: fire_o = en_i & rise_i;
      default:  fire_o = en_i & rise_i & (cnt_q == lim);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i || !en_i)      cnt_q <= '0;
    else if (div_sel && rise_i)   cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm #(
  parameter int DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wrap_i,
  input  logic [DW-1:0] duty_i,
  output logic          pwm_o
);
  logic [DW-1:0] cnt_q, duty_q, cnt_nx;
  logic          out_q;

  assign cnt_nx = cnt_q + DW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      duty_q <= '0;
      out_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      duty_q <= '0;
      out_q  <= 1'b0;
    end else if (wrap_i) begin
      cnt_q  <= '0;
      duty_q <= duty_i;           // duty double-buffered to period boundary
      out_q  <= (duty_i != '0);
    end else begin
      if (cnt_q != '1) cnt_q <= cnt_nx;
      if (cnt_nx == duty_q) out_q <= 1'b0;
    end
  end

  assign pwm_o = out_q;
endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
  import ccp_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int CTRL_W      = 8,
  parameter int DUTY_LO_W   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int CAP_DIV_A   = 4,
  parameter int CAP_DIV_B   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TMR_W-1:0]  tmr_i,
  input  logic              tmr_wrap_i,
  input  logic              pin_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              data_we_i,
  input  logic [TMR_W-1:0]  data_wdata_i,
  input  logic              flag_clr_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [TMR_W-1:0]  data_o,
  output logic              pin_o,
  output logic              flag_o,
  output logic              event_o
);
  localparam int MODE_W    = 4;
  localparam int DUTY_HI_W = 8;
  localparam int DUTY_W    = DUTY_HI_W + DUTY_LO_W;

  logic [MODE_W-1:0]    mode_q;
  logic [DUTY_LO_W-1:0] dlo_q;
  logic [TMR_W-1:0]     data_q;
  logic                 pin_q, flag_q, evt_q, match_q;
  mode_dec_t            dec, new_dec;
  logic                 mode_chg, match_raw, hit;
  logic                 rise, fall, cap_fire, pwm_out;

  assign dec       = decode_mode(mode_q);
  assign new_dec   = decode_mode(ctrl_wdata_i[MODE_W-1:0]);
  assign mode_chg  = ctrl_we_i && (ctrl_wdata_i[MODE_W-1:0] != mode_q);
  assign match_raw = (dec.role == ROLE_CMP) && (tmr_i == data_q);
  assign hit       = match_raw && !match_q;

  ccp_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  ccp_cap_pre #(.DIV_A(CAP_DIV_A), .DIV_B(CAP_DIV_B)) i_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (dec.role == ROLE_CAP),
    .clr_i (mode_chg),
    .sel_i (dec.cap),
    .rise_i(rise),
    .fall_i(fall),
    .fire_o(cap_fire)
  );

  ccp_pwm #(.DW(DUTY_W)) i_pwm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (dec.role == ROLE_PWM),
    .wrap_i(tmr_wrap_i),
    .duty_i({data_q[DUTY_HI_W-1:0], dlo_q}),
    .pwm_o (pwm_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      dlo_q   <= '0;
      data_q  <= '0;
      pin_q   <= 1'b0;
      flag_q  <= 1'b0;
      evt_q   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      if (ctrl_we_i) begin
        mode_q <= ctrl_wdata_i[MODE_W-1:0];
        dlo_q  <= ctrl_wdata_i[MODE_W +: DUTY_LO_W];
      end
      // capture has priority over a software write
      if (cap_fire)       data_q <= tmr_i;
      else if (data_we_i) data_q <= data_wdata_i;

      if (mode_chg) pin_q <= new_dec.entry_lvl;
      else if (hit) begin
        unique case (dec.act)
          ACT_TOGGLE: pin_q <= ~pin_q;
          ACT_SET:    pin_q <= 1'b1;
          ACT_CLR:    pin_q <= 1'b0;
          default:    pin_q <= pin_q;
        endcase
      end

      match_q <= match_raw;
      evt_q   <= hit && dec.evt;

      if (hit || cap_fire) flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (dec.role)
      ROLE_CMP: pin_o = pin_q;
      ROLE_PWM: pin_o = pwm_out;
      default:  pin_o = 1'b0;
    endcase
  end

  assign ctrl_o  = CTRL_W'({dlo_q, mode_q});
  assign data_o  = data_q;
  assign flag_o  = flag_q;
  assign event_o = evt_q;
endmodule

// File: rtl/ccp_channel_chk.sv
module ccp_channel_chk #(
  parameter int TMR_W  = 16,
  parameter int CTRL_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [TMR_W-1:0]  tmr_i,
  input logic              data_we_i,
  input logic              flag_clr_i,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic [TMR_W-1:0]  data_o,
  input logic              pin_o,
  input logic              flag_o,
  input logic              event_o
);
  logic is_off, is_cap;
  assign is_off = (ctrl_o[3:0] == 4'h0) || (ctrl_o[3:0] == 4'h1) || (ctrl_o[3:0] == 4'h3);
  assign is_cap = (ctrl_o[3:2] == 2'b01);

  p_off_pin_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_off |-> !pin_o);
  p_off_no_change_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_off && !data_we_i) |=> ($stable(data_o) && !event_o));
  p_cap_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_cap |-> (!pin_o && !event_o));
  p_evt_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> !event_o);
  p_evt_on_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> ($past(tmr_i == data_o) && ($past(ctrl_o[3:0]) == 4'hB)));
  p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);
  p_evt_sets_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> flag_o);
  p_ctrl_top_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> (ctrl_o[CTRL_W-1:6] == '0));
endmodule

bind ccp_channel ccp_channel_chk #(.TMR_W(TMR_W), .CTRL_W(CTRL_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tmr_i     (tmr_i),
  .data_we_i (data_we_i),
  .flag_clr_i(flag_clr_i),
  .ctrl_o    (ctrl_o),
  .data_o    (data_o),
  .pin_o     (pin_o),
  .flag_o    (flag_o),
  .event_o   (event_o)
);

// File: tb/test_ccp_channel.sv
`timescale 1ns/1ps
module test_ccp_channel;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] tmr_i = '0;
  logic        tmr_wrap_i = 1'b0;
  logic        pin_i = 1'b0;
  logic        ctrl_we_i = 1'b0;
  logic [7:0]  ctrl_wdata_i = '0;
  logic        data_we_i = 1'b0;
  logic [15:0] data_wdata_i = '0;
  logic        flag_clr_i = 1'b0;
  logic [7:0]  ctrl_o;
  logic [15:0] data_o;
  logic        pin_o, flag_o, event_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ccp_channel i_ccp_channel (
    .clk_i(clk), .rst_ni(rst_ni), .tmr_i(tmr_i), .tmr_wrap_i(tmr_wrap_i),
    .pin_i(pin_i), .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
    .data_we_i(data_we_i), .data_wdata_i(data_wdata_i), .flag_clr_i(flag_clr_i),
    .ctrl_o(ctrl_o), .data_o(data_o), .pin_o(pin_o), .flag_o(flag_o),
    .event_o(event_o)
  );

  // compare vectors: mode, compare value, pin on entry, pin after match, event
  typedef struct packed {
    logic [3:0]  mode;
    logic [15:0] cmp;
    logic        entry;
    logic        after;
    logic        evt;
  } vec_t;
  localparam vec_t VEC [5] = '{
    '{4'h2, 16'h0100, 1'b0, 1'b1, 1'b0},  // R5 toggle
    '{4'h8, 16'h0A5A, 1'b0, 1'b1, 1'b0},  // R6 force high
    '{4'h9, 16'hBEEF, 1'b1, 1'b0, 1'b0},  // R6 force low
    '{4'hA, 16'h0033, 1'b0, 1'b0, 1'b0},  // R7 flag only
    '{4'hB, 16'hFFFE, 1'b0, 1'b0, 1'b1}   // R7 special event
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_wdata_i = v; ctrl_we_i = 1'b1; step(1); ctrl_we_i = 1'b0;
  endtask

  task automatic wr_data(input logic [15:0] v);
    data_wdata_i = v; data_we_i = 1'b1; step(1); data_we_i = 1'b0;
  endtask

  task automatic clr_flag();
    flag_clr_i = 1'b1; step(1); flag_clr_i = 1'b0;
  endtask

  task automatic pulse();
    pin_i = 1'b1; step(4); pin_i = 1'b0; step(4);
  endtask

  task automatic pwm_period(input string req, input int exp);
    int hi;
    tmr_wrap_i = 1'b1; step(1); tmr_wrap_i = 1'b0;
    hi = 0;
    for (int i = 0; i < 20; i++) begin hi += int'(pin_o); step(1); end
    chk(req, hi, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(2);
    rst_ni = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 reset ctrl", ctrl_o, 0);
    chk("R1 reset data", data_o, 0);
    chk("R1 reset outs", {pin_o, flag_o, event_o}, 0);
    wr_ctrl(8'hFF);
    chk("R1 top bits read zero", ctrl_o, 8'h3F);
    wr_ctrl(8'h00);

    // table walk over compare modes
    for (int k = 0; k < 5; k++) begin
      wr_ctrl(8'h00);
      tmr_i = 16'h0000;
      wr_data(VEC[k].cmp);
      clr_flag();
      wr_ctrl({4'h0, VEC[k].mode});
      chk("R6 entry level", pin_o, VEC[k].entry);
      chk("R9 flag idle", flag_o, 0);
      tmr_i = VEC[k].cmp;
      step(1);
      chk("R5/R6/R7 pin after match", pin_o, VEC[k].after);
      chk("R7 event on match", event_o, VEC[k].evt);
      chk("R9 flag on match", flag_o, 1);
      tmr_i = 16'h0000;
      step(1);
      chk("R7 event one cycle", event_o, 0);
      chk("R7 pin held", pin_o, VEC[k].after);
    end

    // R8 held equality acts once
    wr_ctrl(8'h00); tmr_i = 0; wr_data(16'h0300); wr_ctrl(8'h02);
    tmr_i = 16'h0300; step(5);
    chk("R8 single toggle", pin_o, 1);
    tmr_i = 16'h0301; step(1); tmr_i = 16'h0300; step(1);
    chk("R8 new match toggles", pin_o, 0);

    // R9 set wins over clear, sticky, clear
    wr_ctrl(8'h00); tmr_i = 0; wr_data(16'h0777); wr_ctrl(8'h0A); clr_flag();
    tmr_i = 16'h0777; flag_clr_i = 1'b1; step(1); flag_clr_i = 1'b0;
    chk("R9 set wins", flag_o, 1);
    chk("R7 pin untouched", pin_o, 0);
    step(3);
    chk("R9 sticky", flag_o, 1);
    clr_flag();
    chk("R9 cleared", flag_o, 0);

    // R2 off / reserved
    wr_ctrl(8'h00); tmr_i = 0; wr_data(16'h0042); wr_ctrl(8'h09);
    chk("R6 1001 entry high", pin_o, 1);
    wr_ctrl(8'h00);
    chk("R2 off drives low", pin_o, 0);
    wr_ctrl(8'h03); clr_flag();
    tmr_i = 16'h0042; step(3);
    chk("R2 reserved no match", flag_o, 0);
    tmr_i = 16'h1111; pulse();
    chk("R2 reserved no capture", data_o, 16'h0042);
    chk("R2 reserved pin", pin_o, 0);

    // R4 divide by 4
    wr_ctrl(8'h00); clr_flag(); wr_ctrl(8'h06);
    for (int p = 1; p <= 3; p++) begin tmr_i = 16'(p * 16); pulse(); end
    chk("R4 no capture before 4th", flag_o, 0);
    tmr_i = 16'h0400; pulse();
    chk("R4 4th edge captures", data_o, 16'h0400);
    chk("R4 flag", flag_o, 1);
    // R4 mode change resets count
    clr_flag();
    pulse(); pulse();
    wr_ctrl(8'h07);
    tmr_i = 16'h0700;
    for (int p = 0; p < 15; p++) pulse();
    chk("R4 count restarted", flag_o, 0);
    tmr_i = 16'h0716; pulse();
    chk("R4 16th edge captures", data_o, 16'h0716);

    // R12 latency, R3 polarity
    wr_ctrl(8'h05); clr_flag();
    tmr_i = 16'h1234; pin_i = 1'b1; step(2);
    chk("R12 not before edge 3", data_o, 16'h0716);
    step(1);
    chk("R12 captured at edge 3", data_o, 16'h1234);
    chk("R3 capture flag", flag_o, 1);
    tmr_i = 16'h5555; pin_i = 1'b0; step(4);
    chk("R3 falling ignored", data_o, 16'h1234);
    wr_ctrl(8'h04);
    tmr_i = 16'h6666; pin_i = 1'b1; step(4);
    chk("R3 rising ignored", data_o, 16'h1234);
    pin_i = 1'b0; step(4);
    chk("R3 falling captures", data_o, 16'h6666);

    // R10 / R11 PWM, 20-cycle periods
    wr_ctrl(8'h00); wr_data(16'h0001); wr_ctrl(8'h2C);  // duty 6
    pwm_period("R10 duty 6", 6);
    tmr_wrap_i = 1'b1; step(1); tmr_wrap_i = 1'b0;
    begin
      int hi;
      hi = int'(pin_o); step(1);
      data_wdata_i = 16'h0003; data_we_i = 1'b1; hi += int'(pin_o); step(1); data_we_i = 1'b0;
      for (int i = 0; i < 18; i++) begin hi += int'(pin_o); step(1); end
      chk("R11 old duty holds", hi, 6);
    end
    pwm_period("R11 new duty 14", 14);
    wr_ctrl(8'h0F);                                   // duty 12
    pwm_period("R10 code 1111 duty 12", 12);
    wr_data(16'h0000); wr_ctrl(8'h0C);
    pwm_period("R10 duty zero", 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule